// File: doc/BRIEF.md
# Segment Load Protection Checker

This block judges each segment-register load in a protected-mode core. The load names a target register (the code register, the stack register, the local-table register, or one of four data registers), a 16-bit selector and a decoded descriptor: present, system and executable flags, a read/write flag and a privilege level. The current privilege level and a task-switch origin flag come with it. The block picks one exception vector for the load, or none, and forms the error code that the exception sequencer pushes.

The result is captured in a register and held until the sequencer acknowledges it, so a slow delivery path never loses a fault. A separate strobe reports a memory access made through a data register that holds a null selector. That access gets a general-protection verdict with an all-zero error code. Vector values used throughout are 10 (invalid task state), 11 (segment not present), 12 (stack fault) and 13 (general protection).

Top module: `seg_load_chk`

## Requirements
- R1: Target encoding is code=0, stack=1, local table=2, data registers=3..6; target 7 never raises a fault.
- R2: A code or data target whose type and privilege checks pass but whose descriptor is not present yields vector 11.
- R3: A stack target whose type and privilege checks pass but whose descriptor is not present yields vector 12, whether or not the load comes from a task switch.
- R4: A stack target with a null selector, a system descriptor, an executable descriptor, a read-only descriptor, or a privilege level or RPL (selector bits 1:0) different from the current level yields vector 13, or vector 10 when the task-switch flag is set.
- R5: A data target with a system descriptor, an executable descriptor that is not readable, or a non-executable descriptor whose privilege level is below the larger of the current level and the RPL yields vector 13.
- R6: A null selector (bits 15:2 all zero) loaded into a data register or the local-table register is accepted without fault. A null selector loaded into the code register yields vector 13, as does a non-executable or system descriptor.
- R7: A local-table target with a non-system descriptor yields vector 13, or 10 from a task switch. A not-present local-table descriptor yields vector 11, or 10 from a task switch.
- R8: Type and privilege errors take priority over the present check, so each load reports exactly one vector.
- R9: A load fault sets the error code to selector bits 15:2 in bits 15:2, the interrupt-table flag in bit 1 and the external-event flag in bit 0.
- R10: A null-access strobe with no faulting load in the same cycle yields vector 13 with error code 0. A faulting load in the same cycle takes precedence.
- R11: The fault flag, vector and code appear one clock after the event and stay unchanged until acknowledge. Events that arrive while a fault is held without acknowledge are dropped.
- R12: Acknowledge clears the fault flag on the next clock unless a new event arrives in the same cycle, in which case that event is captured. Reset clears the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | A segment load is presented this cycle |
| load_target | input | 3 | Register being loaded (encoding in R1) |
| load_sel | input | 16 | Selector being loaded |
| d_present | input | 1 | Descriptor present flag |
| d_system | input | 1 | Descriptor describes a system segment |
| d_exec | input | 1 | Descriptor is executable |
| d_rw | input | 1 | Readable (executable) or writable (data) |
| d_dpl | input | 2 | Descriptor privilege level |
| cur_cpl | input | 2 | Current privilege level |
| from_task | input | 1 | Selector comes from a task-state image |
| ext_event | input | 1 | Load was caused by an external event |
| idt_ref | input | 1 | Selector refers to an interrupt-table entry |
| null_access | input | 1 | Memory access through a null data register |
| fault_ack | input | 1 | Sequencer accepts the held fault |
| fault_o | output | 1 | A fault is held |
| fault_vec_o | output | 8 | Held exception vector |
| fault_code_o | output | 16 | Held error code |

## Verification
The assertions expect load_valid and null_access to be clean single-cycle qualifiers with stable descriptor fields alongside them. They also expect the sequencer to acknowledge only while a fault is held. The stimulus drives every field on the falling edge and pulses load_valid for exactly one cycle. It acknowledges each fault before the next random load, except in the directed cases that probe holding and acknowledge collisions. Random selectors are biased so that null selectors, absent descriptors and each target come up often.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_TSS = 8'd10;
  localparam logic [VEC_W-1:0] VEC_NP  = 8'd11;
  localparam logic [VEC_W-1:0] VEC_SS  = 8'd12;
  localparam logic [VEC_W-1:0] VEC_GP  = 8'd13;

  typedef struct packed {
    logic             hit;
    logic [VEC_W-1:0] vec;
  } verdict_t;
endpackage

// File: rtl/seg_type_check.sv
module seg_type_check
  import seg_chk_pkg::*;
#(
  parameter int TGT_W    = 3,
  parameter int NUM_DATA = 4,
  parameter int PL_W     = 2
) (
  input  logic [TGT_W-1:0] target,
  input  logic             sel_null,
  input  logic [PL_W-1:0]  rpl,
  input  logic             present,
  input  logic             sys,
  input  logic             exec,
  input  logic             rw,
  input  logic [PL_W-1:0]  dpl,
  input  logic [PL_W-1:0]  cpl,
  input  logic             from_task,
  output verdict_t         verdict
);
  localparam int DATA_BASE = 3;

  logic [NUM_DATA-1:0] data_sel;
  logic is_code, is_stack, is_ldt, is_data;
  logic [PL_W-1:0] eff_pl;

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
    assign data_sel[i] = (target == TGT_W'(DATA_BASE + i));
  end

  assign is_code  = (target == TGT_W'(0));
  assign is_stack = (target == TGT_W'(1));
  assign is_ldt   = (target == TGT_W'(2));
  assign is_data  = |data_sel;
  assign eff_pl   = (rpl > cpl) ? rpl : cpl;

  always_comb begin
    verdict.hit = 1'b0;
    verdict.vec = VEC_GP;
    if (is_code) begin
      if (sel_null || sys || !exec) begin
        verdict.hit = 1'b1;
        verdict.vec = VEC_GP;
      end else if (!present) begin
        verdict.hit = 1'b1;
        verdict.vec = VEC_NP;
      end
    end else if (is_stack) begin
      if (sel_null || sys || exec || !rw || (dpl != cpl) || (rpl != cpl)) begin
        verdict.hit = 1'b1;
        verdict.vec = from_task ? VEC_TSS : VEC_GP;
      end else if (!present) begin
        verdict.hit = 1'b1;
        verdict.vec = VEC_SS;
      end
    end else if (is_ldt) begin
      if (!sel_null) begin
        if (!sys) begin
          verdict.hit = 1'b1;
          verdict.vec = from_task ? VEC_TSS : VEC_GP;
        end else if (!present) begin
          verdict.hit = 1'b1;
          verdict.vec = from_task ? VEC_TSS : VEC_NP;
        end
      end
    end else if (is_data) begin
      if (!sel_null) begin
        if (sys || (exec && !rw) || (!exec && (dpl < eff_pl))) begin
          verdict.hit = 1'b1;
          verdict.vec = VEC_GP;
        end else if (!present) begin
          verdict.hit = 1'b1;
          verdict.vec = VEC_NP;
        end
      end
    end
  end
endmodule

// File: rtl/seg_err_code.sv
module seg_err_code #(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             idt,
  input  logic             ext,
  input  logic             use_sel,
  output logic [SEL_W-1:0] code
);
  always_comb begin
    if (use_sel) code = {sel[SEL_W-1:2], idt, ext};
    else         code = '0;
  end
endmodule

// File: rtl/seg_fault_hold.sv
module seg_fault_hold
  import seg_chk_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             event_hit,
  input  logic [VEC_W-1:0] event_vec,
  input  logic [SEL_W-1:0] event_code,
  input  logic             ack,
  output logic             fault,
  output logic [VEC_W-1:0] vec,
  output logic [SEL_W-1:0] code
);
  logic take;
  assign take = event_hit && (!fault || ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault <= 1'b0;
      vec   <= '0;
      code  <= '0;
    end else if (take) begin
      fault <= 1'b1;
      vec   <= event_vec;
      code  <= event_code;
    end else if (ack) begin
      fault <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk
  import seg_chk_pkg::*;
#(
  parameter int SEL_W    = 16,
  parameter int NUM_DATA = 4,
  parameter int PL_W     = 2,
  localparam int TGT_W   = $clog2(NUM_DATA + 3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_valid,
  input  logic [TGT_W-1:0] load_target,
  input  logic [SEL_W-1:0] load_sel,
  input  logic             d_present,
  input  logic             d_system,
  input  logic             d_exec,
  input  logic             d_rw,
  input  logic [PL_W-1:0]  d_dpl,
  input  logic [PL_W-1:0]  cur_cpl,
  input  logic             from_task,
  input  logic             ext_event,
  input  logic             idt_ref,
  input  logic             null_access,
  input  logic             fault_ack,
  output logic             fault_o,
  output logic [VEC_W-1:0] fault_vec_o,
  output logic [SEL_W-1:0] fault_code_o
);
  verdict_t         verdict;
  logic             load_hit;
  logic             sel_null;
  logic [SEL_W-1:0] code_w;
  logic [VEC_W-1:0] vec_w;

  assign sel_null = (load_sel[SEL_W-1:2] == '0);

  seg_type_check #(.TGT_W(TGT_W), .NUM_DATA(NUM_DATA), .PL_W(PL_W)) u_type (
    .target    (load_target),
    .sel_null  (sel_null),
    .rpl       (load_sel[PL_W-1:0]),
    .present   (d_present),
    .sys       (d_system),
    .exec      (d_exec),
    .rw        (d_rw),
    .dpl       (d_dpl),
    .cpl       (cur_cpl),
    .from_task (from_task),
    .verdict   (verdict)
  );

  assign load_hit = load_valid && verdict.hit;
  assign vec_w    = load_hit ? verdict.vec : VEC_GP;

  seg_err_code #(.SEL_W(SEL_W)) u_code (
    .sel     (load_sel),
    .idt     (idt_ref),
    .ext     (ext_event),
    .use_sel (load_hit),
    .code    (code_w)
  );

  seg_fault_hold #(.SEL_W(SEL_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .event_hit  (load_hit || null_access),
    .event_vec  (vec_w),
    .event_code (code_w),
    .ack        (fault_ack),
    .fault      (fault_o),
    .vec        (fault_vec_o),
    .code       (fault_code_o)
  );
endmodule

// File: rtl/seg_load_chk_props.sv
module seg_load_chk_props
  import seg_chk_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int TGT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             load_valid,
  input logic [TGT_W-1:0] load_target,
  input logic [SEL_W-1:0] load_sel,
  input logic             null_access,
  input logic             fault_ack,
  input logic             fault_o,
  input logic [VEC_W-1:0] fault_vec_o,
  input logic [SEL_W-1:0] fault_code_o
);
  // R11
  hold_fault_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o && !fault_ack |=> fault_o && $stable(fault_vec_o) && $stable(fault_code_o));

  // R12
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o && fault_ack && !load_valid && !null_access |=> !fault_o);

  // R12
  reset_clear_chk: assert property (@(posedge clk) rst |=> !fault_o);

  // R8
  legal_vec_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (fault_vec_o >= VEC_TSS && fault_vec_o <= VEC_GP));

  // R3
  stack_vec_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) && fault_vec_o == VEC_SS |-> $past(load_target) == TGT_W'(1));

  // R9
  code_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) && fault_vec_o != VEC_GP |-> fault_code_o[SEL_W-1:2] == $past(load_sel[SEL_W-1:2]));

  // R10
  null_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) && !$past(load_valid) |-> fault_code_o == '0 && fault_vec_o == VEC_GP);
endmodule

bind seg_load_chk seg_load_chk_props #(.SEL_W(SEL_W), .TGT_W(TGT_W)) u_props (
  .clk          (clk),
  .rst          (rst),
  .load_valid   (load_valid),
  .load_target  (load_target),
  .load_sel     (load_sel),
  .null_access  (null_access),
  .fault_ack    (fault_ack),
  .fault_o      (fault_o),
  .fault_vec_o  (fault_vec_o),
  .fault_code_o (fault_code_o)
);

// File: tb/seg_load_chk_test.sv
module seg_load_chk_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_valid = 0, d_present = 0, d_system = 0, d_exec = 0, d_rw = 0;
  logic from_task = 0, ext_event = 0, idt_ref = 0, null_access = 0, fault_ack = 0;
  logic [2:0]  load_target = 0;
  logic [15:0] load_sel = 0;
  logic [1:0]  d_dpl = 0, cur_cpl = 0;
  logic        fault_o;
  logic [7:0]  fault_vec_o;
  logic [15:0] fault_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_load_chk uut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_target(load_target),
    .load_sel(load_sel), .d_present(d_present), .d_system(d_system), .d_exec(d_exec),
    .d_rw(d_rw), .d_dpl(d_dpl), .cur_cpl(cur_cpl), .from_task(from_task),
    .ext_event(ext_event), .idt_ref(idt_ref), .null_access(null_access),
    .fault_ack(fault_ack), .fault_o(fault_o), .fault_vec_o(fault_vec_o),
    .fault_code_o(fault_code_o)
  );

  // expected {hit, vector} for a load, from the requirements
  function automatic logic [8:0] ref_verdict(input logic [2:0] t, input logic [15:0] s,
      input logic p, input logic sy, input logic ex, input logic rw,
      input logic [1:0] dpl, input logic [1:0] cpl, input logic ft);
    logic nul;
    logic [1:0] rpl, eff;
    nul = (s[15:2] == 0);
    rpl = s[1:0];
    eff = (rpl > cpl) ? rpl : cpl;
    if (t == 0) begin
      if (nul || sy || !ex) return {1'b1, 8'd13};
      if (!p) return {1'b1, 8'd11};
    end else if (t == 1) begin
      if (nul || sy || ex || !rw || dpl != cpl || rpl != cpl) return {1'b1, ft ? 8'd10 : 8'd13};
      if (!p) return {1'b1, 8'd12};
    end else if (t == 2) begin
      if (nul) return 9'd0;
      if (!sy) return {1'b1, ft ? 8'd10 : 8'd13};
      if (!p) return {1'b1, ft ? 8'd10 : 8'd11};
    end else if (t <= 6) begin
      if (nul) return 9'd0;
      if (sy || (ex && !rw) || (!ex && dpl < eff)) return {1'b1, 8'd13};
      if (!p) return {1'b1, 8'd11};
    end
    return 9'd0;
  endfunction

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] t, input logic [15:0] s, input logic p,
      input logic sy, input logic ex, input logic rw, input logic [1:0] dpl,
      input logic [1:0] cpl, input logic ft, input logic ext, input logic idt);
    @(negedge clk);
    load_valid = 1; load_target = t; load_sel = s; d_present = p; d_system = sy;
    d_exec = ex; d_rw = rw; d_dpl = dpl; cur_cpl = cpl; from_task = ft;
    ext_event = ext; idt_ref = idt;
    @(negedge clk);
    load_valid = 0;
  endtask

  // one load, check outcome, then acknowledge and check clearing
  task automatic run_load(input string req, input logic [2:0] t, input logic [15:0] s,
      input logic p, input logic sy, input logic ex, input logic rw, input logic [1:0] dpl,
      input logic [1:0] cpl, input logic ft, input logic ext, input logic idt);
    logic [8:0] v;
    logic [15:0] ec;
    v = ref_verdict(t, s, p, sy, ex, rw, dpl, cpl, ft);
    drive(t, s, p, sy, ex, rw, dpl, cpl, ft, ext, idt);
    ec = {s[15:2], idt, ext};
    if (v[8]) check(req, {fault_o, fault_vec_o, fault_code_o}, {1'b1, v[7:0], ec});
    else      check(req, {fault_o, 24'd0}, {1'b0, 24'd0});
    fault_ack = 1;
    @(negedge clk);
    fault_ack = 0;
    check("R12 ack", {24'd0, fault_o}, 25'd0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 0;
    check("R12 reset", {24'd0, fault_o}, 25'd0);

    // directed corner cases
    run_load("R1 invalid target", 3'd7, 16'h0040, 0, 1, 1, 0, 2'd0, 2'd3, 0, 0, 0);
    run_load("R2 code absent",    3'd0, 16'h0108, 0, 0, 1, 1, 2'd0, 2'd0, 0, 1, 0);
    run_load("R2 data absent",    3'd4, 16'h0210, 0, 0, 0, 1, 2'd3, 2'd1, 0, 0, 1);
    run_load("R3 stack absent task", 3'd1, 16'h0302, 0, 0, 0, 1, 2'd2, 2'd2, 1, 0, 0);
    run_load("R4 stack readonly",  3'd1, 16'h0300, 1, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
    run_load("R4 stack ro task",   3'd1, 16'h0300, 1, 0, 0, 0, 2'd0, 2'd0, 1, 1, 0);
    run_load("R5 data exec-only",  3'd6, 16'h0020, 1, 0, 1, 0, 2'd0, 2'd0, 0, 0, 0);
    run_load("R5 data privilege",  3'd3, 16'h0023, 1, 0, 0, 1, 2'd1, 2'd0, 0, 0, 0);
    run_load("R6 null data",       3'd5, 16'h0003, 0, 1, 1, 0, 2'd0, 2'd3, 0, 0, 0);
    run_load("R6 null code",       3'd0, 16'h0001, 1, 0, 1, 1, 2'd0, 2'd0, 0, 1, 1);
    run_load("R7 ldt absent",      3'd2, 16'h0048, 0, 1, 0, 0, 2'd0, 2'd0, 0, 0, 0);
    run_load("R7 ldt absent task", 3'd2, 16'h0048, 0, 1, 0, 0, 2'd0, 2'd0, 1, 0, 0);
    run_load("R8 system beats absent", 3'd4, 16'h0088, 0, 1, 0, 1, 2'd0, 2'd0, 0, 0, 0);
    run_load("R9 code bits",       3'd0, 16'hFFFC, 0, 0, 1, 0, 2'd0, 2'd0, 0, 1, 1);

    // R10 null access alone
    @(negedge clk); null_access = 1;
    @(negedge clk); null_access = 0;
    check("R10 null access", {fault_o, fault_vec_o, fault_code_o}, {1'b1, 8'd13, 16'd0});
    // R11 hold: a new faulting load while held is dropped
    drive(3'd0, 16'h0500, 0, 0, 1, 1, 2'd0, 2'd0, 0, 1, 0);
    check("R11 hold", {fault_o, fault_vec_o, fault_code_o}, {1'b1, 8'd13, 16'd0});
    // R12 ack with a new event in the same cycle captures it
    @(negedge clk);
    fault_ack = 1; load_valid = 1; load_target = 3'd1; load_sel = 16'h0600;
    d_present = 0; d_system = 0; d_exec = 0; d_rw = 1; d_dpl = 0; cur_cpl = 0; from_task = 0;
    ext_event = 0; idt_ref = 0;
    @(negedge clk);
    fault_ack = 0; load_valid = 0;
    check("R12 ack+event", {fault_o, fault_vec_o, fault_code_o}, {1'b1, 8'd12, 16'h0600});
    // R10 faulting load wins over null access in the same cycle
    fault_ack = 1; load_valid = 1; null_access = 1; load_target = 3'd0; load_sel = 16'h0704;
    d_present = 0; d_exec = 1;
    @(negedge clk);
    fault_ack = 0; load_valid = 0; null_access = 0;
    check("R10 load priority", {fault_o, fault_vec_o, fault_code_o}, {1'b1, 8'd11, 16'h0704});
    fault_ack = 1;
    @(negedge clk);
    fault_ack = 0;
    check("R12 clear", {24'd0, fault_o}, 25'd0);

    // constrained random loads
    for (int i = 0; i < 300; i++) begin
      logic [15:0] s;
      s = 16'($urandom);
      if ($urandom_range(0, 7) == 0) s[15:2] = '0;
      run_load("R2/R3/R4/R5/R7/R8/R9 random", 3'($urandom_range(0, 7)), s,
               $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
               1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule